// File: doc/BRIEF.md
# Bit-masked PHY configuration register block

This block holds the control state for a PHY behind a plain register write and read port. Every bus write carries a 32-bit word. The upper halfword of that word is a per-bit enable for the lower halfword. Software can therefore change one field, or a single bit, without reading the register first.

There are three registers. The configuration register drives the PHY's narrow internal configuration port, which has a 6-bit address, a 4-bit data value and a write strobe. The PHY commits a configuration write when the strobe bit goes from 0 to 1. The lane register forces any of four lanes idle. The status register is read-only and shows the PLL lock state and a pending flag for the PLL output enable.

A full configuration write takes three bus writes. The first loads the address and data. The second sets the strobe bit. The third clears it. The block turns the rising strobe into a one-cycle `phy_cfg_we` pulse, which the PHY and the bench can observe directly.

Top module: `phy_cfg_regblk`

## Requirements
- R1: On a write to a writable register, bit x of the lower halfword takes the value of `bus_wdata[x]` when `bus_wdata[x+16]` is 1. When `bus_wdata[x+16]` is 0, bit x keeps its old value.
- R2: `phy_cfg_data` always equals configuration register bits 10:7.
- R3: `phy_cfg_addr` always equals configuration register bits 6:1.
- R4: When a write changes configuration bit 0 from 0 to 1, `phy_cfg_we` is high for exactly one cycle, in the cycle after that write. Any other change of bit 0, and a write that leaves bit 0 at 1, gives no pulse.
- R5: Three writes give exactly one pulse, and that pulse carries the address and data loaded by the first write. The writes are: fields loaded with their enables set and bit 0 masked off, then bit 0 set, then bit 0 cleared.
- R6: `lane_idle[k]` equals lane register bit 3+k for k = 0..3. A value of 1 forces that lane idle.
- R7: A status read returns `pll_locked_i` at bit 9, `pll_pend_i` at bit 10 and zero in every other bit. Writes to the status select change no register.
- R8: A read returns its data on `bus_rdata` in the cycle after `bus_rd`, and the data holds until the next read. The select codes are 0 for configuration, 1 for lane and 2 for status. Configuration and lane reads return the lower 16 bits with the upper halfword at zero. Select 3 reads as zero and ignores writes.
- R9: After reset, every control bit, `phy_cfg_we`, `lane_idle` and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_sel | input | 2 | Register select: 0 configuration, 1 lane, 2 status, 3 unmapped |
| bus_wdata | input | 32 | Write word: upper halfword is the bit enables, lower halfword is the value |
| bus_rdata | output | 32 | Registered read data |
| pll_locked_i | input | 1 | PLL lock indication from the PHY |
| pll_pend_i | input | 1 | PLL output-enable pending indication from the PHY |
| phy_cfg_we | output | 1 | One-cycle commit pulse for the PHY configuration space |
| phy_cfg_addr | output | 6 | PHY configuration address field |
| phy_cfg_data | output | 4 | PHY configuration data field |
| lane_idle | output | 4 | Per-lane forced-idle controls |

## Verification
The case that is hardest to reach from the ports is a strobe rise that comes while the strobe bit is already set, or that is hidden by a masked-off enable. In that case the register holds a 1 without any new rising edge, and no pulse may appear. The random stimulus uses a skewed enable mix of all-zero, all-one and random halfwords. This often leaves bit 0 at 1 across later writes, and it produces writes that set the value bit with its enable clear. Directed sequences then run the three-write commit from a cleared strobe, send writes to the status and unmapped selects, and read back every register to show nothing moved.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned WORD_W  = 2 * HALF_W;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NLANES  = 4;
  localparam int unsigned CA_LSB  = 1;
  localparam int unsigned CA_W    = 6;
  localparam int unsigned CD_LSB  = 7;
  localparam int unsigned CD_W    = 4;
  localparam int unsigned LANE_LSB = 3;
  localparam int unsigned ST_LOCK = 9;
  localparam int unsigned ST_PEND = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG  = 2'd0,
    SEL_LANE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/phy_cfg_rst_sync.sv
module phy_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/phy_cfg_mask_reg.sv
module phy_cfg_mask_reg #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*W-1:0] wr_word,
  output logic [W-1:0]   q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (wr_en && wr_word[W+i]) q_d[i] = wr_word[i];
      else                       q_d[i] = q_r[i];
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_word[W+i]) |=> (q_r[i] == $past(q_r[i]))) // R1
      else $error("masked bit %0d changed", i);

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word[W+i]) |=> (q_r[i] == $past(wr_word[i]))) // R1
      else $error("enabled bit %0d not loaded", i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/phy_cfg_strobe.sv
module phy_cfg_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic level_d_q;
  logic level_d_n;

  always_comb begin
    level_d_n = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d_q <= 1'b0;
    else        level_d_q <= level_d_n;
  end

  assign pulse = level & ~level_d_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse) // R4
    else $error("commit pulse longer than one cycle");
endmodule

// File: rtl/phy_cfg_rdmux.sv
module phy_cfg_rdmux
  import phy_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [HALF_W-1:0] cfg_q,
  input  logic [HALF_W-1:0] lane_q,
  input  logic              pll_locked,
  input  logic              pll_pend,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rdata_d;
  logic [HALF_W-1:0] stat_word;
  logic [HALF_W-1:0] pick;

  always_comb begin
    stat_word          = '0;
    stat_word[ST_LOCK] = pll_locked;
    stat_word[ST_PEND] = pll_pend;
    case (reg_sel_e'(sel))
      SEL_CFG:  pick = cfg_q;
      SEL_LANE: pick = lane_q;
      SEL_STAT: pick = stat_word;
      default:  pick = '0;
    endcase
    rdata_d = rd_en ? {{HALF_W{1'b0}}, pick} : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)) // R8
    else $error("read data changed without a read");
endmodule

// File: rtl/phy_cfg_regblk.sv
module phy_cfg_regblk
  import phy_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pll_locked_i,
  input  logic              pll_pend_i,
  output logic              phy_cfg_we,
  output logic [5:0]        phy_cfg_addr,
  output logic [3:0]        phy_cfg_data,
  output logic [3:0]        lane_idle
);
  logic              rst_i_n;
  logic              cfg_wr;
  logic              lane_wr;
  logic [HALF_W-1:0] cfg_q;
  logic [HALF_W-1:0] lane_q;

  phy_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  always_comb begin
    cfg_wr  = bus_wr && (reg_sel_e'(bus_sel) == SEL_CFG);
    lane_wr = bus_wr && (reg_sel_e'(bus_sel) == SEL_LANE);
  end

  phy_cfg_mask_reg #(.W(HALF_W)) u_cfg (
    .clk(clk), .rst_n(rst_i_n), .wr_en(cfg_wr), .wr_word(bus_wdata), .q(cfg_q)
  );

  phy_cfg_mask_reg #(.W(HALF_W)) u_lane (
    .clk(clk), .rst_n(rst_i_n), .wr_en(lane_wr), .wr_word(bus_wdata), .q(lane_q)
  );

  phy_cfg_strobe u_stb (
    .clk(clk), .rst_n(rst_i_n), .level(cfg_q[0]), .pulse(phy_cfg_we)
  );

  phy_cfg_rdmux u_rd (
    .clk(clk), .rst_n(rst_i_n), .rd_en(bus_rd), .sel(bus_sel),
    .cfg_q(cfg_q), .lane_q(lane_q),
    .pll_locked(pll_locked_i), .pll_pend(pll_pend_i), .rdata(bus_rdata)
  );

  assign phy_cfg_addr = cfg_q[CA_LSB +: CA_W];
  assign phy_cfg_data = cfg_q[CD_LSB +: CD_W];
  assign lane_idle    = lane_q[LANE_LSB +: NLANES];

  AST_WE_CAUSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    phy_cfg_we |-> $past(bus_wr && bus_sel == 2'd0 && bus_wdata[16] && bus_wdata[0])) // R4
    else $error("commit pulse without a strobe-setting write");

  AST_WE_RISE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_wr && bus_wdata[16] && bus_wdata[0] && !cfg_q[0]) |=> phy_cfg_we) // R4
    else $error("strobe rise gave no commit pulse");

  AST_STAT_RD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && bus_sel == 2'd2) |=>
      (bus_rdata == {21'd0, $past(pll_pend_i), $past(pll_locked_i), 9'd0})) // R7
    else $error("status read mismatch");

  AST_NONE_RD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && bus_sel == 2'd3) |=> (bus_rdata == 32'd0)) // R8
    else $error("unmapped read not zero");

  AST_STAT_WR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_wr && bus_sel[1]) |=> ($stable(cfg_q) && $stable(lane_q))) // R7
    else $error("write to read-only select changed state");
endmodule

// File: tb/phy_cfg_regblk_bench.sv
module phy_cfg_regblk_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_sel;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        pll_locked_i, pll_pend_i;
  logic        phy_cfg_we;
  logic [5:0]  phy_cfg_addr;
  logic [3:0]  phy_cfg_data;
  logic [3:0]  lane_idle;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] cfg_m, lane_m;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cfg_regblk u_phy_cfg_regblk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_locked_i(pll_locked_i), .pll_pend_i(pll_pend_i),
    .phy_cfg_we(phy_cfg_we), .phy_cfg_addr(phy_cfg_addr),
    .phy_cfg_data(phy_cfg_data), .lane_idle(lane_idle)
  );

  function automatic logic [15:0] apply_mask(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] read_model(logic [1:0] s, logic lk, logic pd);
    case (s)
      2'd0: return {16'd0, cfg_m};
      2'd1: return {16'd0, lane_m};
      2'd2: return {21'd0, pd, lk, 9'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(logic wr, logic rd, logic [1:0] s, logic [31:0] w,
                       logic lk, logic pd);
    logic [31:0] exp_rd;
    logic        old0;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_sel = s; bus_wdata = w;
    pll_locked_i = lk; pll_pend_i = pd;
    exp_rd = read_model(s, lk, pd);
    old0 = cfg_m[0];
    if (wr && s == 2'd0) cfg_m  = apply_mask(cfg_m, w);
    if (wr && s == 2'd1) lane_m = apply_mask(lane_m, w);
    @(posedge clk);
    #(CLK_PERIOD/4);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R3 cfg address field", {26'd0, phy_cfg_addr}, {26'd0, cfg_m[6:1]});
    check("R2 cfg data field", {28'd0, phy_cfg_data}, {28'd0, cfg_m[10:7]});
    check("R4 commit pulse", {31'd0, phy_cfg_we}, {31'd0, cfg_m[0] & ~old0});
    check("R6 R1 lane idle", {28'd0, lane_idle}, {28'd0, lane_m[6:3]});
    if (rd) check(s == 2'd2 ? "R7 status read" : "R8 read data", bus_rdata, exp_rd);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] w;
    logic [15:0] m;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
    pll_locked_i = 0; pll_pend_i = 0;
    cfg_m = '0; lane_m = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R9 reset state
    check("R9 reset we", {31'd0, phy_cfg_we}, 32'd0);
    check("R9 reset lane", {28'd0, lane_idle}, 32'd0);
    check("R9 reset addr/data", {22'd0, phy_cfg_addr, phy_cfg_data}, 32'd0);
    check("R9 reset rdata", bus_rdata, 32'd0);
    for (int s = 0; s < 4; s++) do_op(0, 1, s[1:0], 32'd0, 0, 0);

    // R5 three-write commit sequence from a cleared strobe
    do_op(1, 0, 2'd0, {16'h07FE, 5'd0, 4'hA, 6'h2D, 1'b0}, 0, 0);
    do_op(1, 0, 2'd0, 32'h0001_0001, 0, 0);
    check("R5 pulse addr", {26'd0, phy_cfg_addr}, 32'h2D);
    check("R5 pulse data", {28'd0, phy_cfg_data}, 32'hA);
    check("R5 pulse we", {31'd0, phy_cfg_we}, 32'd1);
    do_op(1, 0, 2'd0, 32'h0001_0000, 0, 0);
    check("R5 no second pulse", {31'd0, phy_cfg_we}, 32'd0);
    // R4 setting bit 0 again while already 1 gives no pulse
    do_op(1, 0, 2'd0, 32'h0001_0001, 0, 0);
    do_op(1, 0, 2'd0, 32'h0001_0001, 0, 0);
    check("R4 no pulse on held strobe", {31'd0, phy_cfg_we}, 32'd0);
    // R1 value bit with enable clear
    do_op(1, 0, 2'd0, 32'h0000_0000, 0, 0);
    do_op(0, 1, 2'd0, 32'd0, 0, 0);
    // R6 lanes, R7 status writes ignored, R8 unmapped
    do_op(1, 0, 2'd1, 32'h0078_0028, 0, 0);
    do_op(1, 0, 2'd2, 32'hFFFF_FFFF, 1, 1);
    do_op(1, 0, 2'd3, 32'hFFFF_FFFF, 1, 1);
    do_op(0, 1, 2'd0, 32'd0, 0, 0);
    do_op(0, 1, 2'd1, 32'd0, 0, 0);
    do_op(0, 1, 2'd2, 32'd0, 1, 0);
    do_op(0, 1, 2'd2, 32'd0, 0, 1);
    do_op(0, 1, 2'd3, 32'd0, 1, 1);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 3))
        0: m = 16'h0000;
        1: m = 16'hFFFF;
        2: m = 16'h0001;
        default: m = 16'($urandom);
      endcase
      w = {m, 16'($urandom)};
      if ($urandom_range(0, 2) == 0)
        do_op(0, 1, 2'($urandom_range(0, 3)), 32'd0, 1'($urandom), 1'($urandom));
      else
        do_op(1, 0, 2'($urandom_range(0, 3)), w, 1'($urandom), 1'($urandom));
    end

    done = 1;
    finish_run();
  end
endmodule